// File: doc/BRIEF.md
# Character-Cell Video Fetch Sequencer

This block produces one memory fetch address per clock for a character-mapped display. A horizontal count runs across each line and a vertical count across each field. Programmed row and column start positions open a display window. Inside that window the sequencer alternates between two kinds of fetch. One reads a character code from the screen matrix. The next reads one row of that character's glyph from the glyph table. The glyph fetch uses the code that memory returned one cycle after the matrix address was issued. Every fetch not part of the window goes to a fixed idle address.

The window is run by a small phase machine with six states. WAIT holds until the horizontal latch is set, and the transition *arm* then reloads the matrix counter from the running base and moves to ARM. The machine then steps through ARM → COLS, where the column count is captured. Next is COLS → ROWS, where the row count is captured once per field. Next is ROWS → LAUNCH, where fetching starts if the current character row is below the captured row count. Finally LAUNCH → HOLD, and HOLD → HOLD until the line ends. The transition *line-drop* returns any state to WAIT at the end of a drawn line.

The block also reports a coarse video state: sync, burst, border or pixels.

Top module: `charcell_fetch_seq`

## Requirements
- R1: While reset is held, fetch_addr is 0x1C, video_state is border (encoding 2) and display_active is 0.
- R2: A line lasts 71 cycles when pal_mode is 1 and 65 cycles when it is 0. A field lasts 312 or 261 lines respectively. video_state is burst (1) for the last 3 cycles of each line and sync (0) for the 3 cycles before those.
- R3: The vertical latch sets on a cycle whose previous line number, shifted right by one, equals win_first_row. The horizontal latch sets when the vertical latch is set and the horizontal position equals win_first_col. The first matrix fetch appears 3 cycles after the horizontal latch sets.
- R4: The row count is captured once per field, at the second cycle after the horizontal latch. Fetching starts on a line only while the character row is below that count. With a count of 0, nothing is fetched.
- R5: A drawn line makes 2×win_columns fetches. Even fetches go to matrix_base plus the matrix counter, and the counter then increments. Odd fetches go to glyph_base + code_in×8 (×16 when tall_chars=1) + the glyph row. code_in is sampled on the clock edge that produces the odd address.
- R6: At the end of every drawn line the glyph row increments. On reaching 8 (16 when tall) it wraps to 0 and the character row increments.
- R7: A matrix fetch made on glyph row 7 (15 when tall) copies the incremented matrix counter into the base. Each drawn line reloads the matrix counter from the base.
- R8: With no window fetch, fetch_addr is 0x1C. Every address is truncated to 14 bits.
- R9: At field end the vertical count, character row, captured row count, vertical latch, base and glyph row are all cleared, so the next field starts again from matrix_base.
- R10: Outside sync and burst, video_state is pixels (3) while a window fetch is made and border (2) otherwise. display_active is 1 exactly on window-fetch cycles.
- R11: The column counter keeps advancing through sync and burst cycles, and display_active stays 1 there, until the columns run out or the line ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_mode | input | 1 | 1 selects 71-cycle lines and 312-line fields; 0 selects 65 and 261 |
| tall_chars | input | 1 | 1 selects 16-row glyphs, 0 selects 8-row glyphs |
| win_first_row | input | 8 | Vertical window start, in units of two lines |
| win_first_col | input | 7 | Horizontal window start position |
| win_columns | input | 7 | Characters per drawn line |
| win_rows | input | 6 | Character rows per field |
| matrix_base | input | 14 | Start address of the screen matrix |
| glyph_base | input | 14 | Start address of the glyph table |
| code_in | input | 8 | Character code returned for the previous matrix fetch |
| fetch_addr | output | 14 | Registered fetch address |
| display_active | output | 1 | Registered flag: this cycle is a window fetch |
| video_state | output | 2 | Registered state: 0 sync, 1 burst, 2 border, 3 pixels |

## Verification
A fault in the line or field counters moves the sync and burst cycles and the window start. This shows on video_state within one line, or on the first drawn line of the window. A wrong glyph row, character row or matrix base does not show on the first line. It shows as a wrong fetch_addr on the next drawn line, at the next 8- or 16-line boundary, or in the second field. The reference model in the bench is therefore compared on every clock across two full fields, so that these delayed effects are caught at the exact cycle where they first appear.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        ST_SYNC   = 2'd0,
        ST_BURST  = 2'd1,
        ST_BORDER = 2'd2,
        ST_PIXELS = 2'd3
    } vstate_e;

    typedef enum logic [2:0] {
        PH_WAIT   = 3'd0,
        PH_ARM    = 3'd1,
        PH_COLS   = 3'd2,
        PH_ROWS   = 3'd3,
        PH_LAUNCH = 3'd4,
        PH_HOLD   = 3'd5
    } phase_e;

endpackage

// File: rtl/cfs_raster_timer.sv
module cfs_raster_timer #(
    parameter int H_W        = 7,
    parameter int V_W        = 9,
    parameter int PAL_CPL    = 71,
    parameter int NTSC_CPL   = 65,
    parameter int PAL_LINES  = 312,
    parameter int NTSC_LINES = 261
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pal_mode,
    output logic [H_W-1:0] h_next,
    output logic [V_W-2:0] line_half,
    output logic           line_end,
    output logic           field_end,
    output logic [H_W-1:0] cycles_per_line
);
    logic [H_W-1:0] h_q, h_inc;
    logic [V_W-1:0] v_q, v_inc, v_nx, lines;

    always_comb begin
        cycles_per_line = pal_mode ? H_W'(PAL_CPL) : H_W'(NTSC_CPL);
        lines           = pal_mode ? V_W'(PAL_LINES) : V_W'(NTSC_LINES);
        h_inc           = h_q + 1'b1;
        line_end        = (h_inc >= cycles_per_line);
        h_next          = line_end ? '0 : h_inc;
        v_inc           = v_q + 1'b1;
        field_end       = line_end && (v_inc >= lines);
        if (field_end)      v_nx = '0;
        else if (line_end)  v_nx = v_inc;
        else                v_nx = v_q;
        line_half       = v_q[V_W-1:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else begin
            h_q <= h_next;
            v_q <= v_nx;
        end
    end

    // R2
    h_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_q < H_W'(PAL_CPL));

    // R2
    v_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_q < V_W'(PAL_LINES));

endmodule

// File: rtl/cfs_window_seq.sv
module cfs_window_seq
    import cfs_pkg::*;
#(
    parameter int H_W    = 7,
    parameter int V_W    = 9,
    parameter int COL_W  = 7,
    parameter int ROW_W  = 6,
    parameter int CROW_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              field_end,
    input  logic [V_W-2:0]    line_half,
    input  logic [H_W-1:0]    h_next,
    input  logic [V_W-2:0]    first_row,
    input  logic [H_W-1:0]    first_col,
    input  logic [COL_W-1:0]  num_cols,
    input  logic [ROW_W-1:0]  num_rows,
    input  logic [CROW_W-1:0] char_row_nx,
    output logic              hlatch_q,
    output logic              reload,
    output logic              active_nx,
    output logic              fetch_odd
);
    localparam int CC_W = COL_W + 1;

    phase_e             ph_q, ph_drop, ph_d;
    logic               vl_q, vl_d, hl_d, drawn_end;
    logic               cv_q, cv_d, rv_q, rv_d, run_q, run_d;
    logic [COL_W-1:0]   cols_q, cols_d;
    logic [ROW_W-1:0]   rows_q, rows_d;
    logic [CC_W-1:0]    col_q, col_n, col_d;

    // next-state process for the phase machine and its captures
    always_comb begin
        vl_d      = (field_end ? 1'b0 : vl_q) | (first_row == line_half);
        hl_d      = (line_end ? 1'b0 : hlatch_q) | (vl_d && (h_next == first_col));
        drawn_end = line_end && hlatch_q;
        ph_drop   = drawn_end ? PH_WAIT : ph_q;
        cv_d      = drawn_end ? 1'b0 : cv_q;
        cols_d    = cols_q;
        rv_d      = field_end ? 1'b0 : rv_q;
        rows_d    = rows_q;
        run_d     = drawn_end ? 1'b0 : run_q;
        col_n     = drawn_end ? '0 : col_q;
        reload    = 1'b0;

        unique case (ph_drop)
            PH_WAIT: begin
                ph_d   = hl_d ? PH_ARM : PH_WAIT;
                reload = hl_d;
            end
            PH_ARM:    ph_d = PH_COLS;
            PH_COLS:   ph_d = PH_ROWS;
            PH_ROWS:   ph_d = PH_LAUNCH;
            PH_LAUNCH: ph_d = PH_HOLD;
            PH_HOLD:   ph_d = PH_HOLD;
            default:   ph_d = PH_WAIT;
        endcase

        if (ph_d == PH_COLS) begin
            cv_d   = 1'b1;
            cols_d = num_cols;
        end
        if (ph_d == PH_ROWS && !rv_d) begin
            rv_d   = 1'b1;
            rows_d = num_rows;
        end
        if (ph_d == PH_LAUNCH && rv_d && (char_row_nx < {1'b0, rows_d})) begin
            run_d = 1'b1;
            col_n = '0;
        end

        active_nx = run_d && cv_d && (col_n < {cols_d, 1'b0});
        fetch_odd = col_n[0];
        col_d     = active_nx ? col_n + 1'b1 : col_n;
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_WAIT;
            vl_q     <= 1'b0;
            hlatch_q <= 1'b0;
            cv_q     <= 1'b0;
            cols_q   <= '0;
            rv_q     <= 1'b0;
            rows_q   <= '0;
            run_q    <= 1'b0;
            col_q    <= '0;
        end else begin
            ph_q     <= ph_d;
            vl_q     <= vl_d;
            hlatch_q <= hl_d;
            cv_q     <= cv_d;
            cols_q   <= cols_d;
            rv_q     <= rv_d;
            rows_q   <= rows_d;
            run_q    <= run_d;
            col_q    <= col_d;
        end
    end

    // R3
    hold_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_WAIT) |-> hlatch_q);

    // R4
    launch_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> rv_q);

    // R3
    cols_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> cv_q);

endmodule

// File: rtl/cfs_fetch_addr_gen.sv
module cfs_fetch_addr_gen #(
    parameter int ADDR_W    = 14,
    parameter int CODE_W    = 8,
    parameter int CROW_W    = 7,
    parameter logic [ADDR_W-1:0] IDLE_ADDR = 14'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tall,
    input  logic              line_end,
    input  logic              field_end,
    input  logic              hlatch_q,
    input  logic              reload,
    input  logic              active_nx,
    input  logic              fetch_odd,
    input  logic [CODE_W-1:0] code_in,
    input  logic [ADDR_W-1:0] matrix_base,
    input  logic [ADDR_W-1:0] glyph_base,
    output logic [CROW_W-1:0] char_row_nx,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam int G_W = 4;

    logic [G_W-1:0]    glyph_q, glyph_d, last_row;
    logic [G_W:0]      glyph_inc;
    logic [CROW_W-1:0] crow_q;
    logic [ADDR_W-1:0] mcnt_q, mcnt_d, base_q, base_d, addr_d, code_off;

    always_comb begin
        glyph_d     = glyph_q;
        char_row_nx = crow_q;
        base_d      = base_q;
        glyph_inc   = {1'b0, glyph_q} + 1'b1;
        last_row    = tall ? 4'd15 : 4'd7;
        code_off    = tall ? ADDR_W'({code_in, 4'b0000}) : ADDR_W'({code_in, 3'b000});

        if (line_end && hlatch_q) begin
            if (glyph_inc == 5'd16 || (glyph_inc == 5'd8 && !tall)) begin
                glyph_d     = '0;
                char_row_nx = crow_q + 1'b1;
            end else begin
                glyph_d     = glyph_inc[G_W-1:0];
            end
        end
        if (field_end) begin
            glyph_d     = '0;
            char_row_nx = '0;
            base_d      = '0;
        end

        mcnt_d = reload ? base_d : mcnt_q;
        addr_d = IDLE_ADDR;
        if (active_nx) begin
            if (fetch_odd) begin
                addr_d = glyph_base + code_off + ADDR_W'(glyph_d);
            end else begin
                addr_d = matrix_base + mcnt_d;
                mcnt_d = mcnt_d + 1'b1;
                if (glyph_d == last_row) base_d = mcnt_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glyph_q    <= '0;
            crow_q     <= '0;
            mcnt_q     <= '0;
            base_q     <= '0;
            fetch_addr <= IDLE_ADDR;
        end else begin
            glyph_q    <= glyph_d;
            crow_q     <= char_row_nx;
            mcnt_q     <= mcnt_d;
            base_q     <= base_d;
            fetch_addr <= addr_d;
        end
    end

    // R6
    crow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crow_q != $past(crow_q)) |-> ((crow_q == $past(crow_q) + 1'b1) || (crow_q == '0)));

endmodule

// File: rtl/charcell_fetch_seq.sv
module charcell_fetch_seq
    import cfs_pkg::*;
#(
    parameter int PAL_CPL    = 71,
    parameter int NTSC_CPL   = 65,
    parameter int PAL_LINES  = 312,
    parameter int NTSC_LINES = 261,
    parameter int ADDR_W     = 14,
    parameter int COL_W      = 7,
    parameter int ROW_W      = 6,
    parameter int CODE_W     = 8,
    parameter logic [ADDR_W-1:0] IDLE_ADDR = 14'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_mode,
    input  logic              tall_chars,
    input  logic [7:0]        win_first_row,
    input  logic [6:0]        win_first_col,
    input  logic [COL_W-1:0]  win_columns,
    input  logic [ROW_W-1:0]  win_rows,
    input  logic [ADDR_W-1:0] matrix_base,
    input  logic [ADDR_W-1:0] glyph_base,
    input  logic [CODE_W-1:0] code_in,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              display_active,
    output logic [1:0]        video_state
);
    localparam int H_W    = $clog2(PAL_CPL + 1);
    localparam int V_W    = $clog2(PAL_LINES + 1);
    localparam int CROW_W = ROW_W + 1;

    logic [H_W-1:0]    h_next, cpl;
    logic [V_W-2:0]    line_half;
    logic              line_end, field_end;
    logic              hlatch_q, reload, active_nx, fetch_odd;
    logic [CROW_W-1:0] char_row_nx;
    vstate_e           state_d, state_q;

    cfs_raster_timer #(
        .H_W(H_W), .V_W(V_W), .PAL_CPL(PAL_CPL), .NTSC_CPL(NTSC_CPL),
        .PAL_LINES(PAL_LINES), .NTSC_LINES(NTSC_LINES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode),
        .h_next(h_next), .line_half(line_half), .line_end(line_end),
        .field_end(field_end), .cycles_per_line(cpl)
    );

    cfs_window_seq #(
        .H_W(H_W), .V_W(V_W), .COL_W(COL_W), .ROW_W(ROW_W), .CROW_W(CROW_W)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .field_end(field_end),
        .line_half(line_half), .h_next(h_next),
        .first_row(V_W'(win_first_row) >> 0 == '0 ? '0 : win_first_row[V_W-2:0]),
        .first_col(win_first_col[H_W-1:0]),
        .num_cols(win_columns), .num_rows(win_rows), .char_row_nx(char_row_nx),
        .hlatch_q(hlatch_q), .reload(reload), .active_nx(active_nx),
        .fetch_odd(fetch_odd)
    );

    cfs_fetch_addr_gen #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W), .CROW_W(CROW_W), .IDLE_ADDR(IDLE_ADDR)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .tall(tall_chars), .line_end(line_end),
        .field_end(field_end), .hlatch_q(hlatch_q), .reload(reload),
        .active_nx(active_nx), .fetch_odd(fetch_odd), .code_in(code_in),
        .matrix_base(matrix_base), .glyph_base(glyph_base),
        .char_row_nx(char_row_nx), .fetch_addr(fetch_addr)
    );

    // output decode process
    always_comb begin
        if (h_next >= cpl - H_W'(3))      state_d = ST_BURST;
        else if (h_next >= cpl - H_W'(6)) state_d = ST_SYNC;
        else if (active_nx)               state_d = ST_PIXELS;
        else                              state_d = ST_BORDER;
    end

    // output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_BORDER;
            display_active <= 1'b0;
        end else begin
            state_q        <= state_d;
            display_active <= active_nx;
        end
    end

    assign video_state = state_q;

    // R8
    idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !display_active |-> (fetch_addr == IDLE_ADDR));

    // R10
    pixels_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PIXELS) |-> display_active);

endmodule

// File: tb/charcell_fetch_seq_tb.sv
module charcell_fetch_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_mode = 1'b0, tall_chars = 1'b0;
    logic [7:0]  win_first_row = '0;
    logic [6:0]  win_first_col = '0, win_columns = '0;
    logic [5:0]  win_rows = '0;
    logic [13:0] matrix_base = '0, glyph_base = '0;
    logic [7:0]  code_in = '0;
    logic [13:0] fetch_addr;
    logic        display_active;
    logic [1:0]  video_state;

    int errors = 0, checks = 0, wd = 0, k = 0, test = 0, act_cnt = 0;
    // reference model state
    int h, v, vl, hl, plc, cols, rows, col, crow, grow, mc, base;
    int e_addr, e_state, e_act;

    always #5 clk = ~clk;

    charcell_fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .tall_chars(tall_chars),
        .win_first_row(win_first_row), .win_first_col(win_first_col),
        .win_columns(win_columns), .win_rows(win_rows),
        .matrix_base(matrix_base), .glyph_base(glyph_base), .code_in(code_in),
        .fetch_addr(fetch_addr), .display_active(display_active),
        .video_state(video_state)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", wd);
            finish_run();
        end
    end

    task automatic cmp(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s at k=%0d: actual=%0h expected=%0h", req, k, actual, expected);
        end
    endtask

    task automatic model_reset();
        h = 0; v = 0; vl = 0; hl = 0; plc = -1; cols = -1; rows = -1; col = -1;
        crow = 0; grow = 0; mc = 0; base = 0;
        e_addr = 'h1C; e_state = 2; e_act = 0;
    endtask

    task automatic model_step();
        int cpl, lpf, pv, code;
        cpl  = pal_mode ? 71 : 65;
        lpf  = pal_mode ? 312 : 261;
        code = int'(code_in);
        pv = v;
        h++;
        if (h >= cpl) begin
            if (hl != 0) begin
                grow++;
                if (grow == 16 || (grow == 8 && !tall_chars)) begin grow = 0; crow++; end
                plc = -1; cols = -1; col = -1;
            end
            h = 0; hl = 0; v++;
            if (v >= lpf) begin
                v = 0; crow = 0; rows = -1; vl = 0; base = 0; grow = 0;
            end
        end
        if (int'(win_first_row) == pv / 2) vl = 1;
        if (vl != 0 && h == int'(win_first_col)) hl = 1;
        if (plc >= 0) plc++;
        if (plc == -1) begin
            if (hl != 0) begin plc = 0; mc = base; end
        end else if (plc == 1) cols = int'(win_columns);
        else if (plc == 2) begin if (rows < 0) rows = int'(win_rows); end
        else if (plc == 3) begin if (crow < rows) col = 0; end
        e_act = (col >= 0 && col < cols * 2) ? 1 : 0;
        e_addr = 'h1C;
        if (e_act != 0) begin
            if (col % 2 == 1)
                e_addr = int'(glyph_base) + code * (tall_chars ? 16 : 8) + grow;
            else begin
                e_addr = int'(matrix_base) + mc;
                mc = (mc + 1) % 16384;
                if (grow == (tall_chars ? 15 : 7)) base = mc;
            end
            col++;
        end
        e_addr = e_addr % 16384;
        if (h > cpl - 4)      e_state = 1;
        else if (h > cpl - 7) e_state = 0;
        else                  e_state = (e_act != 0) ? 3 : 2;
    endtask

    task automatic directed();
        case (test)
            1: begin
                if (k == 58) cmp("R10 border", int'(video_state), 2);
                if (k == 59) cmp("R2 sync start", int'(video_state), 0);
                if (k == 61) cmp("R2 sync end", int'(video_state), 0);
                if (k == 62) cmp("R2 burst", int'(video_state), 1);
                if (k == 64) cmp("R2 burst last", int'(video_state), 1);
                if (k == 267) cmp("R3 before launch", int'(display_active), 0);
                if (k == 268) begin
                    cmp("R3 launch active", int'(display_active), 1);
                    cmp("R3 first matrix addr", int'(fetch_addr), 'h1000);
                end
                if (k == 269) cmp("R5 glyph addr", int'(fetch_addr), 'h22D0);
                if (k == 325) cmp("R5 fetch count", act_cnt, 8);
                if (k == 333) cmp("R7 reload same row", int'(fetch_addr), 'h1000);
                if (k == 334) cmp("R6 glyph row 1", int'(fetch_addr), 'h22D1);
                if (k == 788) cmp("R7 base after row", int'(fetch_addr), 'h1004);
                if (k == 1763) cmp("R4 last row drawn", int'(fetch_addr), 'h1008);
                if (k == 1828) cmp("R4 rows exhausted", int'(display_active), 0);
                if (k == 17233) begin
                    cmp("R9 new field active", int'(display_active), 1);
                    cmp("R9 new field addr", int'(fetch_addr), 'h1000);
                end
            end
            2: begin
                if (k == 205) cmp("R8 matrix addr", int'(fetch_addr), 'h3FF0);
                if (k == 206) cmp("R8 masked glyph", int'(fetch_addr), 'h06A0);
                if (k == 208) begin
                    cmp("R11 sync state", int'(video_state), 0);
                    cmp("R11 active in sync", int'(display_active), 1);
                end
                if (k == 211) begin
                    cmp("R11 burst state", int'(video_state), 1);
                    cmp("R11 active in burst", int'(display_active), 1);
                end
                if (k == 213) cmp("R11 stop at line end", int'(display_active), 0);
                if (k == 276) cmp("R7 tall reload", int'(fetch_addr), 'h3FF0);
                if (k == 277) cmp("R6 tall glyph row 1", int'(fetch_addr), 'h06A1);
            end
            default: ;
        endcase
    endtask

    task automatic run_test(int id, int cycles);
        test = id; k = 0; act_cnt = 0;
        rst_n = 1'b0;
        model_reset();
        code_in = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset values
        cmp("R1 addr", int'(fetch_addr), 'h1C);
        cmp("R1 state", int'(video_state), 2);
        cmp("R1 active", int'(display_active), 0);
        rst_n = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            k++;
            model_step();
            cmp(e_act != 0 ? "R5 addr" : "R8 addr", int'(fetch_addr), e_addr);
            cmp(e_state < 2 ? "R2 state" : "R10 state", int'(video_state), e_state);
            cmp("R10 active", int'(display_active), e_act);
            if (test == 1 && k > 4 * 65 && k <= 5 * 65) act_cnt += e_act;
            if (test == 3) act_cnt += int'(display_active);
            directed();
            code_in = 8'(e_addr) ^ 8'h5A;
        end
    endtask

    initial begin
        // NTSC, 8-row glyphs
        pal_mode = 1'b0; tall_chars = 1'b0;
        win_first_row = 8'd2; win_first_col = 7'd5; win_columns = 7'd4; win_rows = 6'd3;
        matrix_base = 14'h1000; glyph_base = 14'h2000;
        run_test(1, 17400);
        // PAL, tall glyphs, window running into sync and burst, address wrap
        pal_mode = 1'b1; tall_chars = 1'b1;
        win_first_row = 8'd1; win_first_col = 7'd60; win_columns = 7'd6; win_rows = 6'd2;
        matrix_base = 14'h3FF0; glyph_base = 14'h3C00;
        run_test(2, 3000);
        // zero rows: nothing is ever fetched
        pal_mode = 1'b0; tall_chars = 1'b0;
        win_first_row = 8'd1; win_first_col = 7'd10; win_columns = 7'd3; win_rows = 6'd0;
        matrix_base = 14'h0800; glyph_base = 14'h0400;
        run_test(3, 17000);
        cmp("R4 zero rows no fetch", act_cnt, 0);
        finish_run();
    end
endmodule